// File: doc/BRIEF.md
# DDR SDRAM Command Monitor

This block sits beside a DDR SDRAM command bus and samples the control pins (clock enable, chip select, row strobe, column strobe, write enable, bank address and address) on every rising clock edge. It turns the pin pattern into a compact command code. It keeps its own picture of which banks hold an open row, and it times the quiet periods that follow a refresh, a mode register load or a precharge of every bank.

For each sampled command, the block reports the following one cycle later, from registers:
- the decoded command;
- the target bank;
- the auto-precharge qualifier;
- the mode register selected;
- a strobe that marks the command as illegal for the state the memory is in.

Illegal commands are reported and otherwise ignored: they never change the tracked state. The three quiet periods are cycle counts supplied on input ports, so one instance fits any speed grade.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs clear to zero after that edge, with `cmd_code` = 0 (NOP). Every bank is then idle, no quiet period runs and no read burst is open.
- R2: The command sampled at edge k appears on the outputs after edge k. Chip select high gives code 0 (NOP), as does the pattern row/col/we = H,H,H. With chip select low, the row/col/we patterns decode as follows:
  - L,H,H gives 1 (ACTIVATE);
  - H,L,H gives 2 (READ);
  - H,L,L gives 3 (WRITE);
  - H,H,L gives 4 (BURST STOP);
  - L,H,L gives 5 (PRECHARGE one bank) or 6 (PRECHARGE all);
  - L,L,H gives 7 or 8 (refresh);
  - L,L,L gives 9 (LOAD MODE).
- R3: The refresh pattern decodes as 7 (auto refresh) when clock enable is high and as 8 (self refresh) when it is low. Self refresh starts no quiet period.
- R4: On READ and WRITE, `cmd_autopre` equals address bit 10 and `cmd_bank` equals the bank address. READ or WRITE to a bank with no open row is illegal.
- R5: The precharge pattern with address bit 10 low closes only the addressed bank (code 5, `cmd_bank` = BA). With bit 10 high it closes every bank (code 6), the bank address is ignored, and `cmd_bank` reads 0. `cmd_bank` is 0 for every code other than 1, 2, 3 and 5.
- R6: On LOAD MODE, `cmd_mr_sel` equals bank address bit 0 (0 = mode register, 1 = extended mode register). A bank address above 1 is illegal.
- R7: Auto refresh, self refresh and LOAD MODE are illegal while any bank has an open row.
- R8: A legal auto refresh, LOAD MODE or precharge-all sampled at edge k makes every command other than NOP illegal at edges k+1 through k+T-1. T is `t_rfc`, `t_mrd` or `t_rp` respectively, taken at edge k. A T of 0 or 1 leaves no window, and a new window may start at edge k+T.
- R9: BURST STOP is legal only if the most recent READ, WRITE or BURST STOP was a READ without auto precharge. Otherwise it is illegal.
- R10: An illegal command changes no bank state, starts no quiet period and does not affect burst-stop eligibility.
- R11: A legal READ or WRITE with auto precharge leaves its bank idle for the commands that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| addr | input | ADDR_W | Address bus (bit AP_BIT is the qualifier) |
| t_rfc | input | CNT_W | Refresh quiet period in cycles |
| t_mrd | input | CNT_W | Mode load quiet period in cycles |
| t_rp | input | CNT_W | Precharge-all quiet period in cycles |
| cmd_code | output | 4 | Decoded command code |
| cmd_bank | output | BA_W | Target bank of the command |
| cmd_autopre | output | 1 | Auto precharge qualifier of READ/WRITE |
| cmd_mr_sel | output | 1 | Mode register selected by LOAD MODE |
| illegal | output | 1 | Command illegal for the current state |

## Verification
The expiry of a quiet period and the arrival of a command that opens a fresh one can fall in the same cycle. The bench provokes this by issuing an auto refresh exactly T cycles after a LOAD MODE, then probing the new window at its last illegal cycle and its first free cycle. A command that is illegal both for bank state and because of a running window is also produced, for example an ACTIVATE during the precharge-all window followed by a READ to that bank. The ACTIVATE must be flagged and must leave the bank closed, so the READ that follows must be flagged too. A behavioural model judges every cycle, and a long random phase mixes all patterns with random bank, qualifier and clock-enable values.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;
  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_WR   = 4'd3,
    CMD_BST  = 4'd4,
    CMD_PRE  = 4'd5,
    CMD_PREA = 4'd6,
    CMD_AREF = 4'd7,
    CMD_SREF = 4'd8,
    CMD_LMR  = 4'd9
  } cmd_e;

  typedef struct packed {
    cmd_e code;
    logic ap;
    logic mr_sel;
    logic mr_bad;
  } dec_t;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_mon_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  output dec_t            dec
);
  cmd_e code;

  always_comb begin
    code = CMD_NOP;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  code = CMD_ACT;
        3'b101:  code = CMD_RD;
        3'b100:  code = CMD_WR;
        3'b110:  code = CMD_BST;
        3'b010:  code = a10 ? CMD_PREA : CMD_PRE;
        3'b001:  code = cke ? CMD_AREF : CMD_SREF;
        3'b000:  code = CMD_LMR;
        default: code = CMD_NOP;
      endcase
    end
  end

  always_comb begin
    dec.code   = code;
    dec.ap     = a10 && (code == CMD_RD || code == CMD_WR);
    dec.mr_sel = (code == CMD_LMR) && ba[0];
    dec.mr_bad = (code == CMD_LMR) && (ba > BA_W'(1));
  end
endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker #(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 open_en,
  input  logic                 close_en,
  input  logic                 close_all,
  input  logic [BA_W-1:0]      bank,
  input  logic                 rd_arm,
  input  logic                 rd_disarm,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic                 rd_ok
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst || close_all)
        bank_open[g] <= 1'b0;
      else if (close_en && bank == BA_W'(g))
        bank_open[g] <= 1'b0;
      else if (open_en && bank == BA_W'(g))
        bank_open[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || rd_disarm)
      rd_ok <= 1'b0;
    else if (rd_arm)
      rd_ok <= 1'b1;
  end
endmodule

// File: rtl/ddr_busy_timer.sv
module ddr_busy_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] period,
  output logic             busy
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)
      remain <= '0;
    else if (load)
      remain <= (period == '0) ? '0 : period - CNT_W'(1);
    else if (remain != '0)
      remain <= remain - CNT_W'(1);
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddr_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = $clog2(NUM_BANKS),
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  t_rfc,
  input  logic [CNT_W-1:0]  t_mrd,
  input  logic [CNT_W-1:0]  t_rp,
  output logic [3:0]        cmd_code,
  output logic [BA_W-1:0]   cmd_bank,
  output logic              cmd_autopre,
  output logic              cmd_mr_sel,
  output logic              illegal
);
  dec_t                 dec;
  logic [NUM_BANKS-1:0] bank_open;
  logic                 rd_ok;
  logic                 busy;
  logic                 any_open;
  logic                 sel_open;
  logic                 bad;
  logic                 legal;
  logic                 win_load;
  logic [CNT_W-1:0]     win_len;
  logic                 unused_addr_bits;

  assign unused_addr_bits = ^addr;

  ddr_cmd_decode #(.BA_W(BA_W)) u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .a10(addr[AP_BIT]), .dec(dec)
  );

  assign any_open = |bank_open;
  assign sel_open = bank_open[ba];

  always_comb begin
    bad = 1'b0;
    if (dec.code != CMD_NOP && busy) begin
      bad = 1'b1;
    end else begin
      unique case (dec.code)
        CMD_RD, CMD_WR:     bad = !sel_open;
        CMD_BST:            bad = !rd_ok;
        CMD_AREF, CMD_SREF: bad = any_open;
        CMD_LMR:            bad = any_open || dec.mr_bad;
        default:            bad = 1'b0;
      endcase
    end
  end

  assign legal = !bad;

  ddr_bank_tracker #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_banks (
    .clk(clk), .rst(rst),
    .open_en(legal && dec.code == CMD_ACT),
    .close_en(legal && (dec.code == CMD_PRE || dec.ap)),
    .close_all(legal && dec.code == CMD_PREA),
    .bank(ba),
    .rd_arm(legal && dec.code == CMD_RD && !dec.ap),
    .rd_disarm(legal && (dec.code == CMD_WR || dec.code == CMD_BST ||
                         (dec.code == CMD_RD && dec.ap))),
    .bank_open(bank_open), .rd_ok(rd_ok)
  );

  always_comb begin
    win_load = 1'b0;
    win_len  = '0;
    if (legal) begin
      unique case (dec.code)
        CMD_AREF: begin win_load = 1'b1; win_len = t_rfc; end
        CMD_LMR:  begin win_load = 1'b1; win_len = t_mrd; end
        CMD_PREA: begin win_load = 1'b1; win_len = t_rp;  end
        default:  begin win_load = 1'b0; win_len = '0;    end
      endcase
    end
  end

  ddr_busy_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(win_load), .period(win_len), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_code    <= CMD_NOP;
      cmd_bank    <= '0;
      cmd_autopre <= 1'b0;
      cmd_mr_sel  <= 1'b0;
      illegal     <= 1'b0;
    end else begin
      cmd_code    <= dec.code;
      cmd_bank    <= (dec.code == CMD_ACT || dec.code == CMD_RD ||
                      dec.code == CMD_WR  || dec.code == CMD_PRE) ? ba : '0;
      cmd_autopre <= dec.ap;
      cmd_mr_sel  <= dec.mr_sel;
      illegal     <= bad;
    end
  end
endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk
  import ddr_mon_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [BA_W-1:0]  ba,
  input logic [CNT_W-1:0] t_rfc,
  input logic [3:0]       cmd_code,
  input logic             cmd_autopre,
  input logic             cmd_mr_sel,
  input logic             illegal
);
  // R2: deselect yields NOP, never flagged
  assert_deselect_nop_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (cmd_code == CMD_NOP && !illegal));

  // R8: a NOP is never illegal
  assert_nop_legal_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_code == CMD_NOP) |-> !illegal);

  // R4: qualifier only on READ/WRITE
  assert_autopre_rw_R4: assert property (@(posedge clk) disable iff (rst)
    cmd_autopre |-> (cmd_code == CMD_RD || cmd_code == CMD_WR));

  // R6: register select only on LOAD MODE
  assert_mrsel_lmr_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_mr_sel |-> (cmd_code == CMD_LMR));

  // R6: reserved select flagged
  assert_lmr_reserved_R6: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !ras_n && !cas_n && !we_n && ba > BA_W'(1)) |=> illegal);

  // R8: active command right after legal refresh with a long window
  assert_refresh_window_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_code == CMD_AREF && !illegal && $past(t_rfc) >= CNT_W'(2) &&
     !cs_n && !(ras_n && cas_n && we_n)) |=> illegal);
endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk #(.BA_W(BA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .t_rfc(t_rfc), .cmd_code(cmd_code),
  .cmd_autopre(cmd_autopre), .cmd_mr_sel(cmd_mr_sel), .illegal(illegal)
);

// File: tb/tb_ddr_cmd_monitor.sv
module tb_ddr_cmd_monitor;
  localparam int NB     = 4;
  localparam int BA_W   = 2;
  localparam int ADDR_W = 13;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [BA_W-1:0]   ba = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [CNT_W-1:0]  t_rfc = 8'd6, t_mrd = 8'd2, t_rp = 8'd3;
  logic [3:0]        cmd_code;
  logic [BA_W-1:0]   cmd_bank;
  logic              cmd_autopre, cmd_mr_sel, illegal;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  bit m_open[NB];
  int m_busy = 0;
  bit m_rdok = 0;
  int e_code, e_bank;
  bit e_ap, e_mr, e_ill;

  always #2 clk = ~clk;

  ddr_cmd_monitor #(.NUM_BANKS(NB), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .t_rfc(t_rfc),
    .t_mrd(t_mrd), .t_rp(t_rp), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .cmd_autopre(cmd_autopre), .cmd_mr_sel(cmd_mr_sel), .illegal(illegal)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cycles);
      summary();
    end
  end

  task automatic compare(input string tag);
    checks++;
    if (cmd_code !== 4'(e_code) || cmd_bank !== BA_W'(e_bank) ||
        cmd_autopre !== e_ap || cmd_mr_sel !== e_mr || illegal !== e_ill) begin
      errors++;
      $display("FAIL %s: actual code %0d bank %0d ap %0b mr %0b ill %0b expected code %0d bank %0d ap %0b mr %0b ill %0b",
               tag, cmd_code, cmd_bank, cmd_autopre, cmd_mr_sel, illegal,
               e_code, e_bank, e_ap, e_mr, e_ill);
    end
  endtask

  // reference model: judges the pins present at this edge
  task automatic model_step(input bit k, input bit c, input bit r, input bit a,
                            input bit w, input int b, input bit q);
    int code;
    bit any;
    int per;
    code = 0;
    if (!c) begin
      case ({r, a, w})
        3'b011: code = 1;
        3'b101: code = 2;
        3'b100: code = 3;
        3'b110: code = 4;
        3'b010: code = q ? 6 : 5;
        3'b001: code = k ? 7 : 8;
        3'b000: code = 9;
        default: code = 0;
      endcase
    end
    any = 0;
    foreach (m_open[i]) any |= m_open[i];
    e_code = code;
    e_bank = (code == 1 || code == 2 || code == 3 || code == 5) ? b : 0;
    e_ap   = (code == 2 || code == 3) ? q : 1'b0;
    e_mr   = (code == 9) ? b[0] : 1'b0;
    if (code != 0 && m_busy > 0) e_ill = 1;
    else begin
      case (code)
        2, 3:    e_ill = !m_open[b];
        4:       e_ill = !m_rdok;
        7, 8:    e_ill = any;
        9:       e_ill = any || (b > 1);
        default: e_ill = 0;
      endcase
    end
    if (m_busy > 0) m_busy--;
    if (!e_ill) begin
      per = -1;
      case (code)
        1: m_open[b] = 1;
        2: begin if (q) m_open[b] = 0; m_rdok = !q; end
        3: begin if (q) m_open[b] = 0; m_rdok = 0; end
        4: m_rdok = 0;
        5: m_open[b] = 0;
        6: begin foreach (m_open[i]) m_open[i] = 0; per = int'(t_rp); end
        7: per = int'(t_rfc);
        9: per = int'(t_mrd);
        default: per = -1;
      endcase
      if (per >= 0) m_busy = (per == 0) ? 0 : per - 1;
    end
  endtask

  task automatic issue(input string tag, input bit k, input bit c, input bit r,
                       input bit a, input bit w, input int b, input bit q);
    cke = k; cs_n = c; ras_n = r; cas_n = a; we_n = w; ba = BA_W'(b);
    addr = ADDR_W'($urandom);
    addr[10] = q;
    @(posedge clk);
    model_step(k, c, r, a, w, b, q);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic nop(input string t);            issue(t, 1, 0, 1, 1, 1, 0, 0); endtask
  task automatic desel(input string t);          issue(t, 1, 1, 0, 0, 0, 3, 1); endtask
  task automatic act(input string t, int b);     issue(t, 1, 0, 0, 1, 1, b, 0); endtask
  task automatic rd(input string t, int b, bit q); issue(t, 1, 0, 1, 0, 1, b, q); endtask
  task automatic wr(input string t, int b, bit q); issue(t, 1, 0, 1, 0, 0, b, q); endtask
  task automatic bst(input string t);            issue(t, 1, 0, 1, 1, 0, 2, 0); endtask
  task automatic pre(input string t, int b);     issue(t, 1, 0, 0, 1, 0, b, 0); endtask
  task automatic prea(input string t, int b);    issue(t, 1, 0, 0, 1, 0, b, 1); endtask
  task automatic aref(input string t);           issue(t, 1, 0, 0, 0, 1, 1, 0); endtask
  task automatic sref(input string t);           issue(t, 0, 0, 0, 0, 1, 1, 0); endtask
  task automatic lmr(input string t, int b);     issue(t, 1, 0, 0, 0, 0, b, 0); endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    e_code = 0; e_bank = 0; e_ap = 0; e_mr = 0; e_ill = 0;
    compare("R1 reset state");

    nop("R2 nop");
    desel("R2 deselect");
    rd("R4 read idle bank", 0, 0);
    act("R2 activate b0", 0);
    act("R2 activate b2", 2);
    rd("R4 read open bank", 0, 0);
    bst("R9 stop after read");
    bst("R9 second stop");
    wr("R11 write autoprecharge", 2, 1);
    rd("R11 read closed bank", 2, 0);
    wr("R4 write b0", 0, 0);
    bst("R9 stop after write");
    lmr("R7 mode load with open row", 0);
    aref("R7 refresh with open row");
    sref("R7 self refresh with open row");
    pre("R5 precharge b0", 0);
    lmr("R6 reserved select 3", 3);
    lmr("R6 reserved select 2", 2);
    lmr("R6 extended mode load", 1);
    act("R8 act inside mode window", 1);
    aref("R8 refresh at window end");
    desel("R8 deselect inside refresh window");
    nop("R8 nop in window");
    nop("R8 nop in window");
    nop("R8 nop in window");
    act("R8 act at last busy cycle", 1);
    act("R8 act first free cycle", 1);
    rd("R10 read b1", 1, 0);
    act("R2 activate b3", 3);
    prea("R5 precharge all", 2);
    nop("R8 nop in precharge window");
    act("R10 act in precharge window", 3);
    act("R8 act after precharge window", 0);
    rd("R10 read bank never opened", 3, 0);
    rd("R11 read with autoprecharge", 0, 1);
    rd("R5 read bank closed by precharge all", 1, 0);
    sref("R3 self refresh");
    aref("R3 refresh after self refresh");
    repeat (5) nop("R8 refresh window");
    t_rfc = 8'd1;
    aref("R8 refresh with unit period");
    aref("R8 back to back refresh");
    t_rfc = 8'd0;
    aref("R8 refresh with zero period");
    lmr("R6 base mode load", 0);
    nop("R6 after mode load");

    t_rfc = 8'd4; t_mrd = 8'd3; t_rp = 8'd2;
    for (int i = 0; i < 3000; i++) begin
      bit pc, pk;
      logic [2:0] pat;
      pc = ($urandom_range(0, 7) == 0);
      pk = ($urandom_range(0, 5) != 0);
      pat = 3'($urandom);
      if ($urandom_range(0, 3) == 0) pat = 3'b011;
      issue("R2 random mix", pk, pc, pat[2], pat[1], pat[0],
            $urandom_range(0, NB - 1), 1'($urandom));
    end
    summary();
  end
endmodule